// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register with Forced-State Control

This block is a parameterised bidirectional shift register. Its width defaults to four bits. On each rising clock edge a two-bit mode input selects one of four actions: keep the stored word, move it one place toward bit 0, move it one place toward the top bit, or copy in a parallel word. Shifting toward bit 0 takes a serial bit in at the top. Shifting toward the top takes a serial bit in at bit 0. With these actions the register can work as serial-in/serial-out, serial-in/parallel-out, parallel-in/serial-out or parallel-in/parallel-out. The serial output is bit 0 when shifting down and the top bit when shifting up.

A separate two-bit cell control acts on every storage cell at once. Two of its codes force all bits to 0 or to 1 straight away, without waiting for the clock and regardless of the data inputs. While a force code is applied it also overrides the mode select. The other two codes let the cells behave as ordinary clocked flip-flops. The clear code also serves as the block's reset.

The mode and cell-control pins are plain level controls. The block moves no packets, so it has no valid/ready handshake and no back-pressure. The parallel word is taken on the same edge that sees the load mode, and the output is the stored word itself.

Top module: `usr_core`

## Requirements
- R1: With mode 00 (hold) and a normal cell control, the stored word is unchanged after the clock edge.
- R2: With mode 01 (shift down), bit i takes the old bit i+1 on the clock edge, and the top bit takes the down-shift serial input.
- R3: With mode 10 (shift up), bit i takes the old bit i-1 on the clock edge, and bit 0 takes the up-shift serial input.
- R4: With mode 11 (load), every bit takes the matching bit of the parallel input on the clock edge.
- R5: Cell control 00 drives every stored bit to 0 at once, without a clock edge, and holds it there while applied.
- R6: Cell control 01 drives every stored bit to 1 at once, without a clock edge, and holds it there while applied.
- R7: Cell controls 10 and 11 both give normal clocked operation under the mode select.
- R8: While cell control 00 or 01 is applied, a clock edge leaves the forced value in place under any mode and any data.
- R9: Starting from any word, four shift-down edges leave the four serial bits in the register, with the first one entered at bit 0. The bits shifted out appear at bit 0 in order, oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| mode_i | input | 2 | 00 hold, 01 shift down, 10 shift up, 11 parallel load |
| ser_dn_i | input | 1 | Serial bit entering the top bit during shift down |
| ser_up_i | input | 1 | Serial bit entering bit 0 during shift up |
| par_i | input | W | Parallel word for the load mode |
| cell_ctl_i | input | 2 | 00 force to 0, 01 force to 1, 10 or 11 normal |
| state_o | output | W | Stored word; bit 0 is the down-shift serial output |

## Verification
Each clocked result of R1 to R4, R7 and R9 is due one edge after the inputs that select it. The bench drives inputs on the falling edge, advances its reference model at the rising edge, and compares one nanosecond after that edge. The forced values of R5 and R6 are due with no clock at all. For these the bench applies the force code just after a falling edge and compares about one nanosecond later, before the next rising edge. It compares again after that edge to cover R8. A long random run mixes all modes with forces that arrive part way through sequences, and the model is compared on every clock.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_DN   = 2'b01,
    MODE_UP   = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;

  localparam logic [1:0] CTL_CLEAR = 2'b00;
  localparam logic [1:0] CTL_SET   = 2'b01;
endpackage

// File: rtl/usr_ctl_decode.sv
module usr_ctl_decode (
  input  logic [1:0] ctl_i,
  output logic       clr_o,
  output logic       set_o,
  output logic       run_o
);
  import usr_pkg::*;

  always_comb begin
    clr_o = (ctl_i == CTL_CLEAR);
    set_o = (ctl_i == CTL_SET);
    run_o = ctl_i[1];
  end
endmodule

// File: rtl/usr_next_mux.sv
module usr_next_mux #(
  parameter int W = 4
) (
  input  usr_pkg::usr_mode_e mode_i,
  input  logic               ser_dn_i,
  input  logic               ser_up_i,
  input  logic [W-1:0]       cur_i,
  input  logic [W-1:0]       par_i,
  output logic [W-1:0]       nxt_o
);
  import usr_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_hi;
    logic from_lo;

    if (i == W-1) begin : g_top
      assign from_hi = ser_dn_i;
    end else begin : g_mid_hi
      assign from_hi = cur_i[i+1];
    end

    if (i == 0) begin : g_bot
      assign from_lo = ser_up_i;
    end else begin : g_mid_lo
      assign from_lo = cur_i[i-1];
    end

    always_comb begin
      case (mode_i)
        MODE_DN:   nxt_o[i] = from_hi;
        MODE_UP:   nxt_o[i] = from_lo;
        MODE_LOAD: nxt_o[i] = par_i[i];
        default:   nxt_o[i] = cur_i[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell (
  input  logic clk_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/usr_core.sv
module usr_core #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic [1:0]   mode_i,
  input  logic         ser_dn_i,
  input  logic         ser_up_i,
  input  logic [W-1:0] par_i,
  input  logic [1:0]   cell_ctl_i,
  output logic [W-1:0] state_o
);
  import usr_pkg::*;

  localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

  usr_mode_e    mode_e;
  logic         clr_all;
  logic         set_all;
  logic         run;
  logic [W-1:0] nxt;

  assign mode_e = usr_mode_e'(mode_i);

  usr_ctl_decode u_dec (
    .ctl_i (cell_ctl_i),
    .clr_o (clr_all),
    .set_o (set_all),
    .run_o (run)
  );

  usr_next_mux #(.W(W)) u_mux (
    .mode_i   (mode_e),
    .ser_dn_i (ser_dn_i),
    .ser_up_i (ser_up_i),
    .cur_i    (state_o),
    .par_i    (par_i),
    .nxt_o    (nxt)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    usr_cell u_cell (
      .clk_i (clk_i),
      .clr_i (clr_all),
      .set_i (set_all),
      .d_i   (nxt[i]),
      .q_o   (state_o[i])
    );
  end

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!run)
    (mode_i == 2'b00) |=> (state_o == $past(state_o)));

  a_r2_shift_dn: assert property (@(posedge clk_i) disable iff (!run)
    (mode_i == 2'b01) |=> (state_o == {$past(ser_dn_i), $past(state_o[W-1:1])}));

  a_r3_shift_up: assert property (@(posedge clk_i) disable iff (!run)
    (mode_i == 2'b10) |=> (state_o == {$past(state_o[W-2:0]), $past(ser_up_i)}));

  a_r4_load: assert property (@(posedge clk_i) disable iff (!run)
    (mode_i == 2'b11) |=> (state_o == $past(par_i)));

  a_r5_clear: assert property (@(posedge clk_i)
    (cell_ctl_i == 2'b00) |-> (state_o == '0));

  a_r6_set: assert property (@(posedge clk_i)
    (cell_ctl_i == 2'b01) |-> (state_o == ALL_ONE));

  a_r8_force_wins: assert property (@(posedge clk_i)
    (cell_ctl_i == 2'b00) && $past(cell_ctl_i == 2'b00) |-> $stable(state_o));
endmodule

// File: tb/usr_core_test.sv
`timescale 1ns/100ps
module usr_core_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         sdn = 1'b0;
  logic         sup = 1'b0;
  logic [W-1:0] par = '0;
  logic [1:0]   ctl = 2'b00;
  logic [W-1:0] q;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [W-1:0] model;

  always #2 clk = ~clk;

  usr_core #(.W(W)) uut (
    .clk_i      (clk),
    .mode_i     (mode),
    .ser_dn_i   (sdn),
    .ser_up_i   (sup),
    .par_i      (par),
    .cell_ctl_i (ctl),
    .state_o    (q)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, q, exp, $time);
    end
  endtask

  task automatic step(input string req, input logic [1:0] m, input logic sd,
                      input logic su, input logic [W-1:0] p, input logic [1:0] c);
    @(negedge clk);
    mode = m; sdn = sd; sup = su; par = p; ctl = c;
    if (c == 2'b00 || c == 2'b01) begin
      #1;
      model = (c == 2'b00) ? '0 : '1;
      check(c == 2'b00 ? "R5" : "R6", model);
    end
    @(posedge clk);
    #1;
    if (c[1]) begin
      case (m)
        2'b00: model = model;
        2'b01: model = {sd, model[W-1:1]};
        2'b10: model = {model[W-2:0], su};
        default: model = p;
      endcase
    end
    check(c[1] ? req : "R8", model);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model = '0;
    repeat (2) @(posedge clk);
    #1 check("R5", 4'b0000);
    step("R4", 2'b11, 0, 0, 4'b1011, 2'b10);
    step("R1", 2'b00, 1, 1, 4'b0100, 2'b10);
    step("R2", 2'b01, 1, 0, 4'b0000, 2'b10);
    step("R2", 2'b01, 0, 1, 4'b1111, 2'b10);
    step("R3", 2'b10, 0, 1, 4'b0000, 2'b10);
    step("R3", 2'b10, 0, 0, 4'b0000, 2'b10);
    step("R7", 2'b11, 0, 0, 4'b0110, 2'b11);
    step("R7", 2'b01, 1, 0, 4'b0000, 2'b11);
    // R9: four shift-down edges replace the word with the serial bits
    step("R4", 2'b11, 0, 0, 4'b1001, 2'b10);
    check("R9", 4'b1001);
    step("R9", 2'b01, 0, 0, 4'b0000, 2'b10);
    check("R9", 4'b0100);
    step("R9", 2'b01, 1, 0, 4'b0000, 2'b10);
    step("R9", 2'b01, 1, 0, 4'b0000, 2'b10);
    check("R9", 4'b1100 | {3'b000, 1'b1});
    step("R9", 2'b01, 0, 0, 4'b0000, 2'b10);
    check("R9", 4'b0110);
    step("R6", 2'b11, 0, 0, 4'b0000, 2'b01);
    step("R8", 2'b10, 0, 0, 4'b0000, 2'b01);
    step("R8", 2'b11, 1, 1, 4'b1010, 2'b00);
    step("R8", 2'b01, 1, 1, 4'b1111, 2'b00);
    step("R1", 2'b00, 0, 0, 4'b1111, 2'b10);
    for (int n = 0; n < 400; n++) begin
      logic [1:0] c;
      c = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3));
      step("R7", 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), c);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule